// File: doc/BRIEF.md
# Slot-to-Unit Register Map Copy Engine

This block moves the argument words of a queued command into the register window of the compute unit that will run it. This frees the controlling processor for other work. The processor first writes a one-hot unit mask into the command slot. It then writes the slot index into a trigger register and carries on. The engine reads the slot's header and mask from the command queue memory. From these it works out which words form the register map and where that unit's window lies. It then copies the words one at a time over a memory read port and a memory write port.

Configuration registers set four values: the slot size in bytes, the queue base address, the base address of the first unit, and the log2 of each unit's window size. Triggers that arrive while a copy is running wait in a small FIFO. A mask that does not select exactly one unit cancels that copy and raises a sticky error flag.

Top module: `slotCopyEngine`

## Requirements
- R1: After reset, `busy`, `errFlag`, `rdValid` and `wrValid` are all 0, and the enable bit is clear.
- R2: A write of a slot index to register 1 (trigger) is ignored while the enable bit (register 0, bit 0) is 0. In that case no read or write is issued and `busy` stays 0.
- R3: The header of slot `s` is read at queue base (register 3) plus `s` times the slot size in bytes (register 2). The mask word is read at the next word address.
- R4: The header word carries the payload word count in bits [22:12] and the number of extra mask words in bits [11:10].
- R5: The destination of the first copied word is the unit base (register 4) plus the unit index shifted left by the stride value (register 5). The unit index is the position of the single set bit in the 32-bit mask word.
- R6: The engine copies count − (1 + extra) words. They are taken starting at the word that follows the mask and the extra masks. Word i goes to destination + 4·i.
- R7: When count ≤ 1 + extra, no word is written and the engine returns to idle.
- R8: A mask word that is zero or has more than one bit set writes nothing and sets `errFlag`. `errFlag` stays set through later transfers until any write to register 6 clears it.
- R9: Up to 4 accepted triggers wait while the engine is busy, and they are served in arrival order. A trigger that arrives when 4 are already waiting is dropped.
- R10: Only one memory request is outstanding at a time. A request held without ready keeps its valid, address and data stable.
- R11: `busy` is 1 whenever a transfer is running or a trigger is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select (0 enable, 1 trigger, 2 slot size, 3 queue base, 4 unit base, 5 stride, 6 error clear) |
| regWrData | input | 32 | Register write data |
| rdValid | output | 1 | Queue read request valid |
| rdReady | input | 1 | Queue read request accepted |
| rdAddr | output | 32 | Queue read byte address |
| rspValid | input | 1 | Read data valid, one pulse per accepted request |
| rspData | input | 32 | Read data |
| wrValid | output | 1 | Unit write request valid |
| wrReady | input | 1 | Unit write accepted |
| wrAddr | output | 32 | Unit write byte address |
| wrData | output | 32 | Unit write data |
| busy | output | 1 | Transfer running or trigger waiting |
| errFlag | output | 1 | Sticky bad-mask flag |

## Verification
The assertions assume that the memory side returns exactly one `rspValid` pulse for each accepted read, and never one without a request. They also assume that configuration registers are not rewritten while `busy` is high. The bench memory model meets the first assumption by producing each response a fixed cycle after its handshake. The bench meets the second by changing configuration only after the engine has gone idle. Ready on both ports follows irregular patterns, so the hold properties are exercised during stalls.

// File: rtl/slotCopyPkg.sv
package slotCopyPkg;
  // register select codes
  localparam logic [2:0] RegEnable   = 3'd0;
  localparam logic [2:0] RegTrigger  = 3'd1;
  localparam logic [2:0] RegSlotSize = 3'd2;
  localparam logic [2:0] RegQBase    = 3'd3;
  localparam logic [2:0] RegUnitBase = 3'd4;
  localparam logic [2:0] RegStride   = 3'd5;
  localparam logic [2:0] RegErrClr   = 3'd6;

  // header field positions
  localparam int HdrCountLsb = 12;
  localparam int HdrCountW   = 11;
  localparam int HdrExtraLsb = 10;
  localparam int HdrExtraW   = 2;

  typedef struct packed {
    logic loadSlot;
    logic loadHdr;
    logic loadMask;
    logic loadData;
    logic stepWord;
    logic setErr;
  } pathCtl_t;

  typedef enum logic [2:0] {
    StIdle, StHdrReq, StHdrWait, StMskReq, StMskWait, StDatReq, StDatWait, StWrite
  } ctlState_e;
endpackage

// File: rtl/slotTrigFifo.sv
module slotTrigFifo #(
  parameter int Width = 8,
  parameter int Depth = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [Width-1:0] din,
  input  logic             pop,
  output logic [Width-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PtrW = (Depth > 1) ? $clog2(Depth) : 1;
  localparam int CntW = $clog2(Depth + 1);

  logic [Width-1:0] store [Depth];
  logic [PtrW-1:0]  wrPtr, rdPtr;
  logic [CntW-1:0]  fill;

  assign empty = (fill == '0);
  assign full  = (fill == CntW'(Depth));
  assign dout  = store[rdPtr];

  function automatic logic [PtrW-1:0] bump(input logic [PtrW-1:0] p);
    return (p == PtrW'(Depth - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      fill  <= '0;
    end else begin
      if (push && !full) begin
        store[wrPtr] <= din;
        wrPtr <= bump(wrPtr);
      end
      if (pop && !empty) rdPtr <= bump(rdPtr);
      fill <= fill + CntW'(push && !full) - CntW'(pop && !empty);
    end
  end
endmodule

// File: rtl/slotCopyCtrl.sv
module slotCopyCtrl
  import slotCopyPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     trigPending,
  input  logic     rdReady,
  input  logic     rspValid,
  input  logic     wrReady,
  input  logic     maskBad,
  input  logic     noWords,
  input  logic     lastWord,
  output pathCtl_t ctl,
  output logic     popTrig,
  output logic     rdValid,
  output logic     wrValid,
  output logic     active
);
  ctlState_e state, nextState;

  assign rdValid = (state == StHdrReq) || (state == StMskReq) || (state == StDatReq);
  assign wrValid = (state == StWrite);
  assign active  = (state != StIdle);

  always_comb begin
    nextState = state;
    ctl       = '0;
    popTrig   = 1'b0;
    unique case (state)
      StIdle: if (trigPending) begin
        popTrig = 1'b1;
        ctl.loadSlot = 1'b1;
        nextState = StHdrReq;
      end
      StHdrReq:  if (rdReady) nextState = StHdrWait;
      StHdrWait: if (rspValid) begin
        ctl.loadHdr = 1'b1;
        nextState = StMskReq;
      end
      StMskReq:  if (rdReady) nextState = StMskWait;
      StMskWait: if (rspValid) begin
        if (maskBad) begin
          ctl.setErr = 1'b1;
          nextState = StIdle;
        end else begin
          ctl.loadMask = 1'b1;
          nextState = noWords ? StIdle : StDatReq;
        end
      end
      StDatReq:  if (rdReady) nextState = StDatWait;
      StDatWait: if (rspValid) begin
        ctl.loadData = 1'b1;
        nextState = StWrite;
      end
      StWrite:   if (wrReady) begin
        ctl.stepWord = 1'b1;
        nextState = lastWord ? StIdle : StDatReq;
      end
      default:   nextState = StIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= StIdle;
    else       state <= nextState;
  end
endmodule

// File: rtl/slotCopyPath.sv
module slotCopyPath
  import slotCopyPkg::*;
#(
  parameter int AddrW = 32,
  parameter int DataW = 32,
  parameter int SlotW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [DataW-1:0] regWrData,
  input  pathCtl_t         ctl,
  input  logic [SlotW-1:0] trigSlot,
  input  logic [DataW-1:0] rspData,
  output logic             cfgEnable,
  output logic             maskBad,
  output logic             noWords,
  output logic             lastWord,
  output logic [AddrW-1:0] rdAddr,
  output logic [AddrW-1:0] wrAddr,
  output logic [DataW-1:0] wrData,
  output logic             errFlag
);
  localparam int ShW   = $clog2(AddrW);
  localparam int UnitW = $clog2(DataW);

  logic [AddrW-1:0]     slotSize, qBase, unitBase;
  logic [ShW-1:0]       stride;
  logic [AddrW-1:0]     curSrc, curDst;
  logic [DataW-1:0]     dataReg;
  logic [HdrCountW-1:0] remain;
  logic [HdrExtraW-1:0] extraReg;
  logic [UnitW-1:0]     unitIdx;
  logic [HdrCountW-1:0] hdrCount, hdrNeed;

  assign hdrCount = rspData[HdrCountLsb +: HdrCountW];
  assign hdrNeed  = HdrCountW'(rspData[HdrExtraLsb +: HdrExtraW]) + 1'b1;
  assign maskBad  = (rspData == '0) || ((rspData & (rspData - 1'b1)) != '0);
  assign noWords  = (remain == '0);
  assign lastWord = (remain == HdrCountW'(1));
  assign rdAddr   = curSrc;
  assign wrAddr   = curDst;
  assign wrData   = dataReg;

  always_comb begin
    unitIdx = '0;
    for (int i = 0; i < DataW; i++)
      if (rspData[i]) unitIdx = UnitW'(i);
  end

  // configuration and error registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgEnable <= 1'b0;
      slotSize  <= '0;
      qBase     <= '0;
      unitBase  <= '0;
      stride    <= '0;
      errFlag   <= 1'b0;
    end else begin
      if (regWrEn) begin
        unique case (regAddr)
          RegEnable:   cfgEnable <= regWrData[0];
          RegSlotSize: slotSize  <= AddrW'(regWrData);
          RegQBase:    qBase     <= AddrW'(regWrData);
          RegUnitBase: unitBase  <= AddrW'(regWrData);
          RegStride:   stride    <= regWrData[ShW-1:0];
          default: ;
        endcase
      end
      if (ctl.setErr) errFlag <= 1'b1;
      else if (regWrEn && regAddr == RegErrClr) errFlag <= 1'b0;
    end
  end

  // address walkers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSrc   <= '0;
      curDst   <= '0;
      dataReg  <= '0;
      remain   <= '0;
      extraReg <= '0;
    end else begin
      if (ctl.loadSlot) curSrc <= qBase + AddrW'(trigSlot) * slotSize;
      if (ctl.loadHdr) begin
        extraReg <= rspData[HdrExtraLsb +: HdrExtraW];
        remain   <= (hdrCount > hdrNeed) ? hdrCount - hdrNeed : '0;
        curSrc   <= curSrc + AddrW'(4);
      end
      if (ctl.loadMask) begin
        curSrc <= curSrc + AddrW'(4) + (AddrW'(extraReg) << 2);
        curDst <= unitBase + (AddrW'(unitIdx) << stride);
      end
      if (ctl.loadData) dataReg <= rspData;
      if (ctl.stepWord) begin
        curSrc <= curSrc + AddrW'(4);
        curDst <= curDst + AddrW'(4);
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/slotCopyEngine.sv
module slotCopyEngine
  import slotCopyPkg::*;
#(
  parameter int AddrW     = 32,
  parameter int DataW     = 32,
  parameter int SlotW     = 8,
  parameter int TrigDepth = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [DataW-1:0] regWrData,
  output logic             rdValid,
  input  logic             rdReady,
  output logic [AddrW-1:0] rdAddr,
  input  logic             rspValid,
  input  logic [DataW-1:0] rspData,
  output logic             wrValid,
  input  logic             wrReady,
  output logic [AddrW-1:0] wrAddr,
  output logic [DataW-1:0] wrData,
  output logic             busy,
  output logic             errFlag
);
  pathCtl_t         ctl;
  logic             cfgEnable, maskBad, noWords, lastWord;
  logic             popTrig, trigEmpty, trigFull, active;
  logic [SlotW-1:0] trigSlot;
  logic             trigPush;

  assign trigPush = regWrEn && (regAddr == RegTrigger) && cfgEnable;
  assign busy     = active || !trigEmpty;

  slotTrigFifo #(.Width(SlotW), .Depth(TrigDepth)) i_trigFifo (
    .clk(clk), .rstN(rstN), .push(trigPush), .din(regWrData[SlotW-1:0]),
    .pop(popTrig), .dout(trigSlot), .empty(trigEmpty), .full(trigFull)
  );

  slotCopyCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .trigPending(!trigEmpty), .rdReady(rdReady),
    .rspValid(rspValid), .wrReady(wrReady), .maskBad(maskBad), .noWords(noWords),
    .lastWord(lastWord), .ctl(ctl), .popTrig(popTrig), .rdValid(rdValid),
    .wrValid(wrValid), .active(active)
  );

  slotCopyPath #(.AddrW(AddrW), .DataW(DataW), .SlotW(SlotW)) i_path (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .ctl(ctl), .trigSlot(trigSlot), .rspData(rspData),
    .cfgEnable(cfgEnable), .maskBad(maskBad), .noWords(noWords),
    .lastWord(lastWord), .rdAddr(rdAddr), .wrAddr(wrAddr), .wrData(wrData),
    .errFlag(errFlag)
  );

  logic unusedFull;
  assign unusedFull = trigFull;
endmodule

// File: rtl/slotCopyChecker.sv
module slotCopyChecker #(
  parameter int AddrW = 32,
  parameter int DataW = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [2:0]       regAddr,
  input logic             rdValid,
  input logic             rdReady,
  input logic [AddrW-1:0] rdAddr,
  input logic             wrValid,
  input logic             wrReady,
  input logic [AddrW-1:0] wrAddr,
  input logic [DataW-1:0] wrData,
  input logic             busy,
  input logic             errFlag
);
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rstN)
    rdValid && !rdReady |=> rdValid && $stable(rdAddr));

  a_r10_wr_hold: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid && $stable(wrAddr) && $stable(wrData));

  a_r10_single_request: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && wrValid));

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !(regWrEn && regAddr == 3'd6) |=> errFlag);

  a_r11_busy_covers_traffic: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid || wrValid) |-> busy);

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rstN |=> !rdValid && !wrValid && !errFlag);
endmodule

bind slotCopyEngine slotCopyChecker #(.AddrW(AddrW), .DataW(DataW)) i_slotCopyChecker (.*);

// File: tb/test_slotCopyEngine.sv
module test_slotCopyEngine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        rdValid, rdReady = 1'b0, rspValid = 1'b0;
  logic [31:0] rdAddr, rspData = '0;
  logic        wrValid, wrReady = 1'b0;
  logic [31:0] wrAddr, wrData;
  logic        busy, errFlag;

  always #2.5 clk = ~clk;

  slotCopyEngine i_slotCopyEngine (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr),
    .rspValid(rspValid), .rspData(rspData), .wrValid(wrValid), .wrReady(wrReady),
    .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .errFlag(errFlag)
  );

  int vectors = 0, fails = 0, cyc = 0;
  logic stallRd = 1'b0;
  logic pend = 1'b0;
  logic [31:0] pendAddr = '0;
  logic [31:0] mem [int unsigned];
  logic [63:0] expQ [$];
  logic expErr = 1'b0;
  logic [31:0] mQBase = 0, mSlotSize = 0, mUnitBase = 0, mStride = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] memRd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return a ^ 32'h5A5A_0000;
  endfunction

  // memory model and per-clock comparison of write traffic
  always @(negedge clk) begin
    cyc++;
    rspValid = 1'b0;
    if (pend) begin
      rspValid = 1'b1;
      rspData = memRd(pendAddr);
      pend = 1'b0;
    end
    rdReady = !stallRd && (cyc % 3 != 1);
    wrReady = (cyc % 4 != 2);
    if (rstN && rdValid && rdReady) begin
      pend = 1'b1;
      pendAddr = rdAddr;
    end
    if (rstN && wrValid && wrReady) begin
      if (expQ.size() == 0)
        check(0, "R2/R6/R7/R8 unexpected write", {wrAddr, wrData}, 64'h0);
      else begin
        logic [63:0] e;
        e = expQ.pop_front();
        check({wrAddr, wrData} == e, "R3/R5/R6 write addr/data", {wrAddr, wrData}, e);
      end
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    case (a)
      3'd2: mSlotSize = d;
      3'd3: mQBase = d;
      3'd4: mUnitBase = d;
      3'd5: mStride = d;
      default: ;
    endcase
  endtask

  task automatic setSlot(input int idx, input int count, input int extra, input logic [31:0] mask);
    logic [31:0] a;
    a = mQBase + idx * mSlotSize;
    mem[a] = (32'(count) << 12) | (32'(extra) << 10) | 32'h1;  // R4 field layout
    mem[a + 4] = mask;
  endtask

  // reference model: predicts the writes for an accepted trigger
  task automatic trigger(input int idx, input bit accept);
    if (accept) begin
      logic [31:0] a, hdr, mask;
      int cnt, ext, n, u;
      a = mQBase + idx * mSlotSize;
      hdr = memRd(a); mask = memRd(a + 4);
      cnt = int'(hdr[22:12]); ext = int'(hdr[11:10]);
      if (mask == 0 || $countones(mask) != 1) expErr = 1'b1;
      else begin
        u = 0;
        for (int i = 0; i < 32; i++) if (mask[i]) u = i;
        n = (cnt > 1 + ext) ? cnt - 1 - ext : 0;
        for (int i = 0; i < n; i++)
          expQ.push_back({mUnitBase + (32'(u) << mStride) + 32'(4 * i),
                          memRd(a + 32'(4 * (2 + ext + i)))});
      end
    end
    regWrite(3'd1, 32'(idx));
  endtask

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 4) begin
      @(negedge clk);
      quiet = (!busy && !pend) ? quiet + 1 : 0;
    end
  endtask

  task automatic checkDrained(input string req);
    check(expQ.size() == 0, req, 64'(expQ.size()), 64'd0);
    check(errFlag == expErr, {req, " errFlag"}, 64'(errFlag), 64'(expErr));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(!busy && !errFlag && !rdValid && !wrValid, "R1 reset outputs",
          {60'd0, busy, errFlag, rdValid, wrValid}, 64'd0);
    rstN = 1'b1;
    regWrite(3'd2, 32'h100);
    regWrite(3'd3, 32'h1000_0000);
    regWrite(3'd4, 32'h4000_0000);
    regWrite(3'd5, 32'd16);

    // R2: trigger while disabled is ignored
    setSlot(2, 5, 0, 32'h4);
    trigger(2, 1'b0);
    repeat (10) @(negedge clk);
    check(!busy, "R2 busy stays low when disabled", 64'(busy), 64'd0);
    checkDrained("R2");

    regWrite(3'd0, 32'h1);
    // R3 R5 R6: basic copy, unit 2, 4 words
    setSlot(3, 5, 0, 32'h4);
    trigger(3, 1'b1);
    waitIdle();
    checkDrained("R3/R5/R6 basic");

    // R4 R6: extra masks skipped, top unit, other stride, top slot index
    regWrite(3'd5, 32'd12);
    setSlot(255, 6, 2, 32'h8000_0000);
    trigger(255, 1'b1);
    waitIdle();
    checkDrained("R4/R6 extra masks");

    // R7: nothing to copy
    setSlot(5, 1, 0, 32'h1);
    trigger(5, 1'b1);
    setSlot(6, 2, 3, 32'h2);
    trigger(6, 1'b1);
    waitIdle();
    checkDrained("R7 empty map");

    // R8: bad masks set sticky error, good copy still runs
    setSlot(7, 4, 0, 32'h0);
    trigger(7, 1'b1);
    waitIdle();
    checkDrained("R8 zero mask");
    setSlot(8, 4, 1, 32'h6);
    trigger(8, 1'b1);
    setSlot(9, 3, 0, 32'h10);
    trigger(9, 1'b1);
    waitIdle();
    checkDrained("R8 sticky through good copy");
    regWrite(3'd6, 32'h0);
    expErr = 1'b0;
    check(errFlag == 1'b0, "R8 error clear", 64'(errFlag), 64'd0);

    // R9 R11: queue of four behind a stalled transfer, sixth dropped
    regWrite(3'd5, 32'd16);
    for (int s = 20; s < 26; s++) setSlot(s, 3 + (s % 3), 0, 32'h1 << (s - 20));
    stallRd = 1'b1;
    trigger(20, 1'b1);
    repeat (3) @(negedge clk);
    for (int s = 21; s < 26; s++) trigger(s, s < 25);
    repeat (5) @(negedge clk);
    check(busy, "R11 busy while stalled and queued", 64'(busy), 64'd1);
    stallRd = 1'b0;
    waitIdle();
    checkDrained("R9 fifo order and overflow drop");
    check(!busy, "R11 busy clears when idle", 64'(busy), 64'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule